// File: doc/BRIEF.md
# 24-Hour Minute/Hour Timekeeper with Button Adjust

This block keeps wall-clock time in 24-hour form for a four-digit seven-segment display. A slow reference clock (nominally 32768 Hz) enters as a plain level signal. It is brought into the master clock domain, and its rising edges are counted down to one step pulse per minute. The step advances a minute counter, which carries into an hour counter.

For setting the time, an adjust switch disconnects the minute pulse. The minute counter then takes its steps from two push buttons. Each button is synchronised and debounced. A press gives one step at once, and a held button repeats after a pause. Steps in either direction carry or borrow across the hour boundary and wrap at midnight. When adjust mode ends, the minute prescaler starts again from zero, so the first minute after setting lasts a full minute. The current time is decoded by table lookup into four segment patterns, and the leading hour digit is always shown, including zero.

Top module: `clk24_top`

## Requirements
- R1: After reset the time is 00:00, and each of the four digits shows the zero pattern 7'h3F.
- R2: Outside adjust mode, the minute advances by one after TICKS_PER_MIN rising edges of ref_clk. The default is 1966080, which is 60 s at 32768 Hz.
- R3: The hour stays within 0..23 and the minute stays within 0..59.
- R4: Stepping up from minute 59 gives minute 0 and adds one to the hour. From 23:59, stepping up gives 00:00.
- R5: Stepping down from minute 0 gives minute 59 and takes one from the hour. From 00:00, stepping down gives 23:59.
- R6: While adjust_sw is high, ref_clk edges do not change the time, and each up or down step comes from the buttons. While adjust_sw is low, the buttons have no effect.
- R7: A button held longer than the debounce time gives one step right away. It gives a second step RPT_DELAY cycles later, and one more step every RPT_PERIOD cycles after that.
- R8: When the up and down step pulses arrive in the same cycle, the time does not change.
- R9: A button or switch level that lasts fewer than DEB_CYCLES master cycles is ignored.
- R10: The minute prescaler is held at zero for as long as adjust mode is active. After adjust mode ends, the first minute step needs a full TICKS_PER_MIN ref_clk edges.
- R11: The seg_out bus is split into four fields, from the top: [27:21] hour tens, [20:14] hour units, [13:7] minute tens, [6:0] minute units. In each field, bits 6..0 drive segments g..a, and a 1 lights the segment. The patterns for 0..9 are 3F,06,5B,4F,66,6D,7D,07,7F,6F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Slow timebase level, asynchronous to clk |
| adjust_sw | input | 1 | Adjust-mode switch, asynchronous |
| btn_up | input | 1 | Step-up button, asynchronous, active high |
| btn_dn | input | 1 | Step-down button, asynchronous, active high |
| hours | output | 5 | Current hour, binary 0..23 |
| minutes | output | 6 | Current minute, binary 0..59 |
| seg_out | output | 28 | Four segment patterns, hour tens in the top field |

## Verification
The bench steps across both ends of the day. From 00:00 it steps down and expects 23:59, then steps back up and expects 00:00. A design with the wrong modulus would show hour 31 or minute 63, or would fail to come back to 00:00. It runs the normal timebase through a full hour to reach the 00:59 to 01:00 carry, and it times the gap between minute steps exactly. An off-by-one prescaler gives a gap of 56 or 72 cycles instead of 64. It holds a button and counts the auto-repeat steps, presses both buttons together, sends a glitch shorter than the debounce time, presses buttons outside adjust mode, and measures the first minute after adjust mode ends. A prescaler that keeps counting during adjust mode gives a short first minute.

// File: rtl/clk24_pkg.sv
package clk24_pkg;

    localparam int HR_MAX = 23;
    localparam int MN_MAX = 59;

    typedef struct packed {
        logic [4:0] hr;
        logic [5:0] mn;
    } hm_t;

    typedef enum logic {
        RP_FIRST,
        RP_REPEAT
    } rpt_ph_e;

    function automatic logic [6:0] seg_lut(input logic [3:0] d);
        logic [6:0] p;
        case (d)
            4'd0:    p = 7'h3F;
            4'd1:    p = 7'h06;
            4'd2:    p = 7'h5B;
            4'd3:    p = 7'h4F;
            4'd4:    p = 7'h66;
            4'd5:    p = 7'h6D;
            4'd6:    p = 7'h7D;
            4'd7:    p = 7'h07;
            4'd8:    p = 7'h7F;
            4'd9:    p = 7'h6F;
            default: p = 7'h00;
        endcase
        return p;
    endfunction

    function automatic logic [13:0] two_digits(input logic [5:0] v);
        logic [5:0] t;
        logic [5:0] u;
        t = v / 6'd10;
        u = v - t * 6'd10;
        return {seg_lut(t[3:0]), seg_lut(u[3:0])};
    endfunction

endpackage

// File: rtl/clk24_prescale.sv
module clk24_prescale #(
    parameter int TICKS_PER_MIN = 1966080
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic ref_clk,
    output logic min_tick
);
    localparam int CW = (TICKS_PER_MIN > 1) ? $clog2(TICKS_PER_MIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_MIN - 1);

    logic [2:0]    ref_sh;
    logic          ref_rise;
    logic [CW-1:0] cnt;

    assign ref_rise = ref_sh[1] & ~ref_sh[2];
    assign min_tick = ref_rise & (cnt == LAST) & ~clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_sh <= '0;
            cnt    <= '0;
        end else begin
            ref_sh <= {ref_sh[1:0], ref_clk};
            if (clear || min_tick)
                cnt <= '0;
            else if (ref_rise)
                cnt <= cnt + 1'b1;
        end
    end

    // R10
    presc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0));

endmodule

// File: rtl/clk24_debounce.sv
module clk24_debounce #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level
);
    localparam int DW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [DW-1:0] DLAST = DW'(DEB_CYCLES - 1);

    logic [1:0]    sync_q;
    logic [DW-1:0] stab;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            stab   <= '0;
            level  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == level) begin
                stab <= '0;
            end else if (stab == DLAST) begin
                stab  <= '0;
                level <= sync_q[1];
            end else begin
                stab <= stab + 1'b1;
            end
        end
    end

    // R9
    deb_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (level != $past(level)) |-> (level == $past(sync_q[1])));

endmodule

// File: rtl/clk24_repeat.sv
module clk24_repeat
    import clk24_pkg::*;
#(
    parameter int RPT_DELAY  = 8000000,
    parameter int RPT_PERIOD = 2000000
) (
    input  logic clk,
    input  logic rst,
    input  logic held,
    output logic pulse
);
    localparam int RMAX = (RPT_DELAY > RPT_PERIOD) ? RPT_DELAY : RPT_PERIOD;
    localparam int RW   = (RMAX > 1) ? $clog2(RMAX) : 1;
    localparam logic [RW-1:0] D_LAST = RW'(RPT_DELAY - 1);
    localparam logic [RW-1:0] P_LAST = RW'(RPT_PERIOD - 1);

    logic          held_q;
    logic [RW-1:0] rc;
    rpt_ph_e       ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            rc     <= '0;
            ph     <= RP_FIRST;
            pulse  <= 1'b0;
        end else begin
            held_q <= held;
            pulse  <= 1'b0;
            if (!held) begin
                rc <= '0;
                ph <= RP_FIRST;
            end else if (!held_q) begin
                pulse <= 1'b1;
                rc    <= '0;
                ph    <= RP_FIRST;
            end else if ((ph == RP_FIRST && rc == D_LAST) ||
                         (ph == RP_REPEAT && rc == P_LAST)) begin
                pulse <= 1'b1;
                rc    <= '0;
                ph    <= RP_REPEAT;
            end else begin
                rc <= rc + 1'b1;
            end
        end
    end

    // R7
    rpt_gap_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/clk24_counter.sv
module clk24_counter
    import clk24_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step_up,
    input  logic step_dn,
    output hm_t  tm
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tm <= '0;
        end else if (step_up && !step_dn) begin
            if (tm.mn == 6'(MN_MAX)) begin
                tm.mn <= '0;
                tm.hr <= (tm.hr == 5'(HR_MAX)) ? 5'd0 : tm.hr + 5'd1;
            end else begin
                tm.mn <= tm.mn + 6'd1;
            end
        end else if (step_dn && !step_up) begin
            if (tm.mn == 6'd0) begin
                tm.mn <= 6'(MN_MAX);
                tm.hr <= (tm.hr == 5'd0) ? 5'(HR_MAX) : tm.hr - 5'd1;
            end else begin
                tm.mn <= tm.mn - 6'd1;
            end
        end
    end

    // R3
    range_chk: assert property (@(posedge clk) disable iff (rst)
        (tm.hr <= 5'(HR_MAX)) && (tm.mn <= 6'(MN_MAX)));

    // R4
    carry_up_chk: assert property (@(posedge clk) disable iff (rst)
        (step_up && !step_dn && tm.mn == 6'(MN_MAX) && tm.hr != 5'(HR_MAX))
        |=> (tm.mn == 6'd0) && (tm.hr == $past(tm.hr) + 5'd1));

    // R5
    borrow_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (step_dn && !step_up && tm.mn == 6'd0 && tm.hr == 5'd0)
        |=> (tm.mn == 6'(MN_MAX)) && (tm.hr == 5'(HR_MAX)));

endmodule

// File: rtl/clk24_top.sv
module clk24_top
    import clk24_pkg::*;
#(
    parameter int TICKS_PER_MIN = 1966080,
    parameter int DEB_CYCLES    = 16,
    parameter int RPT_DELAY     = 8000000,
    parameter int RPT_PERIOD    = 2000000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_clk,
    input  logic        adjust_sw,
    input  logic        btn_up,
    input  logic        btn_dn,
    output logic [4:0]  hours,
    output logic [5:0]  minutes,
    output logic [27:0] seg_out
);
    localparam int NIN = 3;   // 0: up, 1: down, 2: adjust
    localparam int NBT = 2;

    logic [NIN-1:0] raw_in;
    logic [NIN-1:0] clean;
    logic [NBT-1:0] bpulse;
    logic           adj;
    logic           min_tick;
    logic           step_up;
    logic           step_dn;
    hm_t            tm;

    assign raw_in = {adjust_sw, btn_dn, btn_up};
    assign adj    = clean[2];

    for (genvar i = 0; i < NIN; i++) begin : g_in
        clk24_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
            .clk(clk), .rst(rst), .raw(raw_in[i]), .level(clean[i])
        );
    end

    for (genvar j = 0; j < NBT; j++) begin : g_rpt
        clk24_repeat #(.RPT_DELAY(RPT_DELAY), .RPT_PERIOD(RPT_PERIOD)) u_rpt (
            .clk(clk), .rst(rst), .held(clean[j] & adj), .pulse(bpulse[j])
        );
    end

    clk24_prescale #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_pre (
        .clk(clk), .rst(rst), .clear(adj), .ref_clk(ref_clk), .min_tick(min_tick)
    );

    assign step_up = adj ? bpulse[0] : min_tick;
    assign step_dn = adj ? bpulse[1] : 1'b0;

    clk24_counter u_cnt (
        .clk(clk), .rst(rst), .step_up(step_up), .step_dn(step_dn), .tm(tm)
    );

    assign hours   = tm.hr;
    assign minutes = tm.mn;
    assign seg_out = {two_digits({1'b0, tm.hr}), two_digits(tm.mn)};

    // R8
    both_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (adj && bpulse[0] && bpulse[1]) |=> $stable(minutes) && $stable(hours));

    // R6
    adj_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (adj && !bpulse[0] && !bpulse[1]) |=> $stable(minutes));

endmodule

// File: tb/clk24_top_bench.sv
module clk24_top_bench;
    localparam int TPM = 8;
    localparam int DEB = 4;
    localparam int RD  = 40;
    localparam int RP  = 10;
    localparam int MINC = TPM * 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_clk = 1'b0;
    logic        adjust_sw = 1'b0;
    logic        btn_up = 1'b0;
    logic        btn_dn = 1'b0;
    logic [4:0]  hours;
    logic [5:0]  minutes;
    logic [27:0] seg_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    clk24_top #(.TICKS_PER_MIN(TPM), .DEB_CYCLES(DEB), .RPT_DELAY(RD), .RPT_PERIOD(RP)) u_clk24_top (
        .clk(clk), .rst(rst), .ref_clk(ref_clk), .adjust_sw(adjust_sw),
        .btn_up(btn_up), .btn_dn(btn_dn),
        .hours(hours), .minutes(minutes), .seg_out(seg_out)
    );

    always #2.5 clk = ~clk;

    initial begin
        forever begin
            repeat (4) @(posedge clk);
            #1 ref_clk = ~ref_clk;
        end
    end

    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; default: return 7'h6F;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic chk_time(input string req, input int h, input int m);
        chk({req, " hour"}, hours, h);
        chk({req, " minute"}, minutes, m);
        chk({req, " seg"}, seg_out,
            {pat(h / 10), pat(h % 10), pat(m / 10), pat(m % 10)});
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit adj);
        @(posedge clk); #1;
        rst = 1'b1; btn_up = 1'b0; btn_dn = 1'b0; adjust_sw = adj;
        cyc(3);
        @(posedge clk); #1 rst = 1'b0;
        cyc(DEB + 6);
    endtask

    task automatic press(input bit up, input bit dn, input int n);
        @(posedge clk); #1 btn_up = up; btn_dn = dn;
        cyc(n);
        @(posedge clk); #1 btn_up = 1'b0; btn_dn = 1'b0;
        cyc(DEB + 8);
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        chk_time("R1 reset", 0, 0);
        chk("R11 hour tens zero shown", seg_out[27:21], 7'h3F);
    endtask

    task automatic t_minute_rate;
        int n;
        int last;
        do_reset(1'b0);
        n = 0;
        while (minutes == 0 && n < 500) begin cyc(1); n++; end
        last = minutes;
        n = 0;
        while (minutes == last && n < 500) begin cyc(1); n++; end
        chk("R2 minute period", n, MINC);
    endtask

    task automatic t_hour_carry;
        int n = 0;
        do_reset(1'b0);
        while (hours == 0 && n < 70 * MINC) begin cyc(1); n++; end
        chk_time("R4 carry 00:59->01:00", 1, 0);
        chk_range("R3 minute range", minutes, 0, 59);
    endtask

    task automatic t_buttons_idle;
        do_reset(1'b0);
        press(1'b1, 1'b0, 12);
        chk("R6 button ignored outside adjust", minutes, 0);
    endtask

    task automatic t_adjust;
        int n;
        do_reset(1'b1);
        press(1'b0, 1'b1, 10);
        chk_time("R5 borrow 00:00->23:59", 23, 59);
        press(1'b1, 1'b0, 10);
        chk_time("R4 wrap 23:59->00:00", 0, 0);
        press(1'b1, 1'b0, 10);
        chk("R6 single up press", minutes, 1);
        press(1'b1, 1'b1, 12);
        chk("R8 both buttons no step", minutes, 1);
        press(1'b1, 1'b0, DEB - 2);
        chk("R9 short glitch ignored", minutes, 1);
        cyc(5 * MINC);
        chk("R6 timebase ignored in adjust", minutes, 1);
        @(posedge clk); #1 btn_up = 1'b1;
        n = 0;
        while (minutes == 1 && n < 100) begin cyc(1); n++; end
        chk("R7 first step", minutes, 2);
        cyc(RD + 2 * RP + 5);
        chk("R7 repeat steps", minutes, 5);
        @(posedge clk); #1 btn_up = 1'b0;
        cyc(DEB + 20);
        n = minutes;
        @(posedge clk); #1 adjust_sw = 1'b0;
        begin
            int c = 0;
            while (minutes == n && c < 500) begin cyc(1); c++; end
            chk_range("R10 full minute after adjust", c, MINC, MINC + DEB + 16);
        end
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_minute_rate();
                t_hour_carry();
                t_buttons_idle();
                t_adjust();
                done = 1;
            end
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    checks++; errors++;
                    $display("FAIL watchdog actual=timeout expected=completion");
                end
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule